// File: doc/BRIEF.md
# Interrupt-capable general-purpose I/O port

An eight-pin I/O port with a plain synchronous register bus. Each pin is either a software-owned input or output, or is handed to a peripheral that then supplies the output value and enable. A pin may also act as an open-drain output, which drives the pad low for a 0 and releases it for a 1. A digital-enable bit per pin gates the input path. Pin inputs are synchronised through two flops before any software read or interrupt detection sees them.

Every pin has its own interrupt detector. It can work on rising, falling or both edges, which latch until software clears them, or on high or low level, which follows the pin. A per-pin mask gates each raw flag, and the masked flags are ORed into one interrupt line. A write to any sense-configuration register re-evaluates every edge-mode pin against its new active level, so an unmasked pin can fire spuriously; software masks the pin, configures it, then clears it. A parameter picks the pins that come out of reset in peripheral mode. Drive, pull and slew registers are only stored.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 0, the peripheral-select register reads the parameter `AF_RESET` (default 8'hC0), the digital enable, mask, latched flags and `irq_o` are all 0.
- R2: Register addresses on `addr_i`: 0 data, 1 direction, 2 peripheral select, 3 open-drain, 4 digital enable, 5 sense (0 edge, 1 level), 6 both-edges, 7 event (1 rising/high, 0 falling/low), 8 mask, 9 raw status (read-only), 10 masked status (read-only), 11 clear (write-only, reads 0), 12 drive, 13 pull, 14 slew. A data read returns, per bit, the data register where the effective direction is output, otherwise the synchronised pin AND digital enable; a pin change is seen in reads after two rising clock edges.
- R3: Where the peripheral-select bit is 1, `pad_out_o` and the effective direction come from `alt_out_i` and `alt_oe_i`; where it is 0 they come from the data and direction registers.
- R4: A pin is open-drain when effective direction, open-drain and digital enable are all 1; then `pad_od_o` is 1, `pad_out_o` is 0 and `pad_oe_o` is the inverse of the output value. Otherwise `pad_od_o` is 0, `pad_out_o` is the output value and `pad_oe_o` the effective direction.
- R5: With digital enable 0 a pin reads 0 as an input and raises no raw interrupt, edge or level.
- R6: In edge mode a rising edge (event 1), a falling edge (event 0), or either edge (both-edges 1) sets the pin's latched flag on the third rising clock edge after the pin changes; the flag holds until cleared.
- R7: In level mode the raw flag equals digital enable AND (synchronised pin equals the event bit); it does not latch.
- R8: Writing 1 to a bit of the clear register drops that pin's latched flag; a 0 bit has no effect; a detection in the same cycle wins over the clear.
- R9: Masked status is raw status AND mask; `irq_o` is 1 exactly when any masked bit is 1.
- R10: One cycle after any write to sense, both-edges or event, each enabled edge-mode pin whose synchronised level matches its new active level (always, for both-edges) has its flag latched on the following edge.
- R11: The drive, pull and slew registers read back what was written and change no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| pin_i | input | 8 | Pad input levels |
| alt_out_i | input | 8 | Peripheral output values |
| alt_oe_i | input | 8 | Peripheral output enables |
| pad_out_o | output | 8 | Pad output value |
| pad_oe_o | output | 8 | Pad output enable |
| pad_od_o | output | 8 | Pad open-drain flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
Register writes take effect at the write's clock edge, so pad outputs and register reads are sampled at the following falling edge. A pin change reaches reads and level flags after two rising edges and edge flags after three, and the bench checks that the edge flag is still clear after two and set after three. A sense-configuration write latches spurious flags two edges later, so the bench waits two idle cycles before clearing them. All samples are taken at falling edges, away from the edge that updates state.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 4;
  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 4'd0,  A_DIR   = 4'd1,  A_ALT  = 4'd2,  A_OPEN = 4'd3,
    A_DEN   = 4'd4,  A_SENSE = 4'd5,  A_BOTH = 4'd6,  A_EVT  = 4'd7,
    A_MASK  = 4'd8,  A_RAW   = 4'd9,  A_MST  = 4'd10, A_CLR  = 4'd11,
    A_DRV   = 4'd12, A_PULL  = 4'd13, A_SLEW = 4'd14
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/gpio_pad.sv
module gpio_pad #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] alt_i,
  input  logic [W-1:0] alt_out_i,
  input  logic [W-1:0] alt_oe_i,
  input  logic [W-1:0] open_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] eff_dir_o,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_od_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic val, dir, od;
    assign val = alt_i[i] ? alt_out_i[i] : data_i[i];
    assign dir = alt_i[i] ? alt_oe_i[i]  : dir_i[i];
    assign od  = dir & open_i[i] & den_i[i];
    assign eff_dir_o[i] = dir;
    assign pad_od_o[i]  = od;
    assign pad_out_o[i] = od ? 1'b0 : val;
    assign pad_oe_o[i]  = od ? ~val : dir;
  end

  always_comb begin
    // p_od_low_r4: an open-drain pin never drives high
    assert ((pad_od_o & pad_out_o) == '0);
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] den_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] event_i,
  input  logic         cfg_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  logic [W-1:0] prev_q, latch_q, latch_d;
  logic [W-1:0] rise, fall, edge_hit, cfg_hit, match, lvl;
  logic         cfg_seen_q;

  assign rise  = sync_i & ~prev_q;
  assign fall  = ~sync_i & prev_q;
  assign match = ~(sync_i ^ event_i);
  assign edge_hit = den_i & ~sense_i &
                    ((both_i & (rise | fall)) |
                     (~both_i & event_i & rise) |
                     (~both_i & ~event_i & fall));
  // config write re-evaluates edge pins against their new active level
  assign cfg_hit = cfg_seen_q ? (den_i & ~sense_i & (both_i | match)) : '0;
  assign latch_d = (latch_q & ~(clr_we_i ? clr_i : '0)) | edge_hit | cfg_hit;
  assign lvl     = den_i & sense_i & match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      latch_q    <= '0;
      cfg_seen_q <= 1'b0;
    end else begin
      prev_q     <= sync_i;
      latch_q    <= latch_d;
      cfg_seen_q <= cfg_we_i;
    end
  end

  assign raw_o    = (sense_i & lvl) | (~sense_i & latch_q);
  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;

  // p_latch_hold_r8: latched flags only drop on a clear write
  p_latch_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((latch_q & $past(latch_q)) == $past(latch_q)));
  // p_den_gate_r5: no new flag on a pin whose digital enable was 0
  p_den_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(den_i)) == '0));
  // p_irq_mask_r9: the interrupt line needs an unmasked pin
  p_irq_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_i != '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int            N_PINS   = 8,
  parameter logic [N_PINS-1:0] AF_RESET = 8'hC0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] alt_out_i,
  input  logic [N_PINS-1:0] alt_oe_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] pad_od_o,
  output logic              irq_o
);
  localparam int W = N_PINS;

  logic [W-1:0] data_q, dir_q, alt_q, open_q, den_q;
  logic [W-1:0] sense_q, both_q, evt_q, mask_q;
  logic [W-1:0] drv_q, pull_q, slew_q;
  logic [W-1:0] sync, eff_dir, raw, masked;
  logic         cfg_we, clr_we;
  reg_addr_e    a;

  assign a      = reg_addr_e'(addr_i);
  assign cfg_we = we_i && (a == A_SENSE || a == A_BOTH || a == A_EVT);
  assign clr_we = we_i && (a == A_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0; dir_q <= '0; alt_q <= AF_RESET; open_q <= '0;
      den_q <= '0; sense_q <= '0; both_q <= '0; evt_q <= '0;
      mask_q <= '0; drv_q <= '0; pull_q <= '0; slew_q <= '0;
    end else if (we_i) begin
      case (a)
        A_DATA:  data_q  <= wdata_i;
        A_DIR:   dir_q   <= wdata_i;
        A_ALT:   alt_q   <= wdata_i;
        A_OPEN:  open_q  <= wdata_i;
        A_DEN:   den_q   <= wdata_i;
        A_SENSE: sense_q <= wdata_i;
        A_BOTH:  both_q  <= wdata_i;
        A_EVT:   evt_q   <= wdata_i;
        A_MASK:  mask_q  <= wdata_i;
        A_DRV:   drv_q   <= wdata_i;
        A_PULL:  pull_q  <= wdata_i;
        A_SLEW:  slew_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync)
  );

  gpio_pad #(.W(W)) u_pad (
    .data_i(data_q), .dir_i(dir_q), .alt_i(alt_q), .alt_out_i(alt_out_i),
    .alt_oe_i(alt_oe_i), .open_i(open_q), .den_i(den_q),
    .eff_dir_o(eff_dir), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
    .pad_od_o(pad_od_o)
  );

  gpio_irq #(.W(W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync), .den_i(den_q),
    .sense_i(sense_q), .both_i(both_q), .event_i(evt_q), .cfg_we_i(cfg_we),
    .clr_we_i(clr_we), .clr_i(wdata_i), .mask_i(mask_q),
    .raw_o(raw), .masked_o(masked), .irq_o(irq_o)
  );

  always_comb begin
    case (a)
      A_DATA:  rdata_o = (eff_dir & data_q) | (~eff_dir & den_q & sync);
      A_DIR:   rdata_o = dir_q;
      A_ALT:   rdata_o = alt_q;
      A_OPEN:  rdata_o = open_q;
      A_DEN:   rdata_o = den_q;
      A_SENSE: rdata_o = sense_q;
      A_BOTH:  rdata_o = both_q;
      A_EVT:   rdata_o = evt_q;
      A_MASK:  rdata_o = mask_q;
      A_RAW:   rdata_o = raw;
      A_MST:   rdata_o = masked;
      A_DRV:   rdata_o = drv_q;
      A_PULL:  rdata_o = pull_q;
      A_SLEW:  rdata_o = slew_q;
      default: rdata_o = '0;
    endcase
  end

  // p_od_release_r4: an open-drain pin with output 1 is released
  p_od_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_od_o & ~alt_q & data_q) != '0) |-> ((pad_oe_o & pad_od_o & ~alt_q & data_q) == '0));
  // p_alt_dir_r3: a peripheral-owned pin follows the peripheral enable when not open-drain
  p_alt_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (((pad_oe_o ^ alt_oe_i) & alt_q & ~pad_od_o) == '0));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int W = 8;
  localparam logic [W-1:0] AFR = 8'hC0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic we = 1'b0;
  logic [W-1:0] wdata = '0, rdata, pins = '0, aout = '0, aoe = '0;
  logic [W-1:0] pout, poe, pod;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_port #(.N_PINS(W), .AF_RESET(AFR)) u_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .alt_out_i(aout), .alt_oe_i(aoe),
    .pad_out_o(pout), .pad_oe_o(poe), .pad_od_o(pod), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] det(input logic [2:0] m, input bit rising);
    // m: 0 rising, 1 falling, 2 both
    return (m == 2) || (m == 0 && rising) || (m == 1 && !rising) ? 8'h01 : 8'h00;
  endfunction

  initial begin
    logic [W-1:0] r, ed, eo;
    idle(2); rst_n = 1'b1; idle(1);
    // R1 reset state
    rd(4'd1, r); chk("R1 dir", r, 8'h00);
    rd(4'd2, r); chk("R1 alt", r, AFR);
    rd(4'd4, r); chk("R1 den", r, 8'h00);
    rd(4'd9, r); chk("R1 raw", r, 8'h00);
    chk("R1 oe", poe, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R5 den=0 input reads zero
    pins = 8'hFF; idle(3);
    rd(4'd0, r); chk("R5 den0 read", r, 8'h00);
    wr(4'd4, 8'hFF);

    // R2 input reads with two-edge latency
    foreach (ed[k]) ed[k] = 1'b0;
    for (int v = 0; v < 256; v += 37) begin
      logic [W-1:0] prev;
      prev = pins;
      @(negedge clk); pins = W'(v);
      @(negedge clk); rd(4'd0, r); chk("R2 one edge", r, prev);
      @(negedge clk); rd(4'd0, r); chk("R2 two edges", r, W'(v));
    end

    // R3 software vs peripheral ownership
    wr(4'd0, 8'h96); wr(4'd1, 8'h0F);
    aout = 8'h80; aoe = 8'hC0; pins = 8'h5A; idle(3);
    for (int s = 0; s < 4; s++) begin
      logic [W-1:0] alt;
      alt = (s == 0) ? AFR : (s == 1) ? 8'h00 : (s == 2) ? 8'hFF : 8'h33;
      wr(4'd2, alt);
      eo = (alt & aout) | (~alt & 8'h96);
      ed = (alt & aoe) | (~alt & 8'h0F);
      chk("R3 pad_out", pout, eo);
      chk("R3 pad_oe", poe, ed);
      rd(4'd0, r); chk("R2 mixed read", r, (ed & 8'h96) | (~ed & 8'h5A));
    end

    // R4 open drain, sweep output values
    wr(4'd2, 8'h00); wr(4'd1, 8'hFF); wr(4'd3, 8'hF0);
    for (int d = 0; d < 256; d++) begin
      wr(4'd0, W'(d));
      chk("R4 od", pod, 8'hF0);
      chk("R4 out", pout, W'(d) & 8'h0F);
      chk("R4 oe", poe, 8'h0F | (8'hF0 & ~W'(d)));
    end
    wr(4'd4, 8'h3F);
    chk("R4 den gates od", pod, 8'h30);

    // R11 stored-only registers
    eo = pout; ed = poe;
    wr(4'd12, 8'hA1); wr(4'd13, 8'h5C); wr(4'd14, 8'h7E);
    rd(4'd12, r); chk("R11 drv", r, 8'hA1);
    rd(4'd13, r); chk("R11 pull", r, 8'h5C);
    rd(4'd14, r); chk("R11 slew", r, 8'h7E);
    chk("R11 out", pout, eo); chk("R11 oe", poe, ed);

    // R6/R8 edge detection per mode and pin
    wr(4'd3, 8'h00); wr(4'd1, 8'h00); wr(4'd4, 8'hFF); wr(4'd8, 8'h00);
    pins = 8'h00; idle(3);
    for (int m = 0; m < 3; m++) begin
      wr(4'd5, 8'h00); wr(4'd6, (m == 2) ? 8'hFF : 8'h00);
      wr(4'd7, (m == 0) ? 8'hFF : 8'h00);
      idle(2); wr(4'd11, 8'hFF);
      rd(4'd9, r); chk("R8 clear all", r, 8'h00);
      for (int p = 0; p < W; p++) begin
        @(negedge clk); pins = 8'h01 << p;
        idle(2); rd(4'd9, r); chk("R6 not yet", r, 8'h00);
        idle(1); rd(4'd9, r); chk("R6 rise", r, det(3'(m), 1'b1) << p);
        @(negedge clk); pins = 8'h00;
        idle(3); rd(4'd9, r);
        chk("R6 fall", r, (det(3'(m), 1'b1) | det(3'(m), 1'b0)) << p);
        wr(4'd11, 8'h00); rd(4'd9, r);
        chk("R8 zero no effect", r, (det(3'(m), 1'b1) | det(3'(m), 1'b0)) << p);
        wr(4'd11, 8'h01 << p); rd(4'd9, r); chk("R8 cleared", r, 8'h00);
      end
    end

    // R10 config write re-evaluation
    wr(4'd6, 8'h00); wr(4'd7, 8'h00);
    pins = 8'h0F; idle(4); wr(4'd11, 8'hFF);
    wr(4'd7, 8'hFF); idle(1);
    rd(4'd9, r); chk("R10 reeval", r, 8'h0F);

    // R8 partial clear, R9 mask
    wr(4'd11, 8'h05); rd(4'd9, r); chk("R8 partial", r, 8'h0A);
    wr(4'd8, 8'h02); rd(4'd10, r); chk("R9 masked", r, 8'h02);
    chk("R9 irq on", {7'b0, irq}, 8'h01);
    wr(4'd8, 8'h01); rd(4'd10, r); chk("R9 masked off", r, 8'h00);
    chk("R9 irq off", {7'b0, irq}, 8'h00);

    // R7 level mode
    wr(4'd8, 8'h00);
    wr(4'd5, 8'hFF); wr(4'd7, 8'hF0);
    pins = 8'h3C; idle(3); rd(4'd9, r); chk("R7 level a", r, 8'h33);
    pins = 8'hC3; idle(3); rd(4'd9, r); chk("R7 level b", r, 8'hCC);
    wr(4'd8, 8'hFF); chk("R9 level irq", {7'b0, irq}, 8'h01);
    wr(4'd4, 8'h0F); rd(4'd9, r); chk("R5 den0 level", r, 8'h0C);
    wr(4'd4, 8'h00); rd(4'd9, r); chk("R5 den0 none", r, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule